// File: doc/BRIEF.md
# Overcurrent Timed Latch-Off Controller

This block is the digital sequencing core of a single-channel load switch protector. Its inputs are four synchronous flags: a supply-good flag with hysteresis already applied, an enable pin whose active level is chosen by a parameter, an overcurrent flag and an over-temperature flag. From these it decides when the power switch is on. It also decides how the output is discharged when the switch is off: either by a controlled slow ramp or by a fast pulldown.

When overcurrent appears while the switch is on, the controller enters current regulation. The analog loop holds the load at its limit, and the switch stays on for a fixed period counted from a tick prescaler. If overcurrent is still present when that period ends, the switch latches off with the fast pulldown and an active-low fault output falls. The fault output cannot fall inside a blanking window that starts at turn-on. It falls only once per latch-off. It clears when the enable is released or when the supply goes bad.

The period lengths are given as whole numbers of prescaler ticks (`REG_TICKS`, `BLANK_TICKS`). Each tick lasts `TICK_DIV` clock cycles.

Top module: `ocp_latch_ctrl`

## Requirements
- R1: After reset the outputs are `sw_on`=0, `fast_off`=1, `reg_active`=0 and `fault_n`=1.
- R2: `sw_on` rises one cycle after `supply_ok`=1 and the enable at its active level are both present, provided `ot_flag`=0. With `EN_ACTIVE_HIGH`=1 the enable is active when `en_pin`=1; with `EN_ACTIVE_HIGH`=0 it is active when `en_pin`=0. Without both conditions the switch stays off.
- R3: When `oc_flag`=1 while the switch is on, `reg_active` becomes 1 one cycle later and `sw_on` stays 1.
- R4: If `oc_flag` stays 1, `reg_active` stays high for exactly `TICK_DIV*REG_TICKS+1` cycles. The switch then latches off with `fast_off`=1.
- R5: If `oc_flag` returns to 0 before the latch-off, the switch stays on and `reg_active` drops. A later overcurrent gets a fresh full period.
- R6: `fault_n` falls no earlier than `TICK_DIV*BLANK_TICKS` cycles after `sw_on` rose. If the latch-off happened earlier, `fault_n` falls exactly at that count. Otherwise it falls in the same cycle as `sw_on`.
- R7: Once `fault_n`=0, it stays 0 and `sw_on` stays 0 for as long as supply and enable stay active, whatever `oc_flag` does.
- R8: Releasing the enable returns `fault_n` to 1 one cycle later. Reasserting the enable starts a new turn-on.
- R9: When `supply_ok`=0, the next cycle shows `sw_on`=0, `reg_active`=0, `fast_off`=1 and `fault_n`=1.
- R10: Releasing the enable while the switch is on and not regulating gives `fast_off`=0 (slow ramp). Releasing it during regulation gives `fast_off`=1.
- R11: When `ot_flag`=1 the switch is off one cycle later with `fast_off`=1 and no fault. Two cycles after `ot_flag` clears, with the enable still active, the switch is on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above lockout level, hysteresis applied |
| en_pin | input | 1 | Enable pin; active level is set by `EN_ACTIVE_HIGH` |
| oc_flag | input | 1 | Load current at or above the regulation limit |
| ot_flag | input | 1 | Die over-temperature |
| sw_on | output | 1 | Power switch on command |
| fast_off | output | 1 | Discharge mode while off: 1 fast pulldown, 0 slow ramp |
| reg_active | output | 1 | Current regulation period running |
| fault_n | output | 1 | Latched overcurrent fault, active low |

## Verification
Two events can land in the same cycle: the end of the start-up blanking window and the latch-off at the end of a regulation period. The bench turns the switch on and then sweeps the overcurrent onset over successive cycles. Some onsets make the latch-off fall before the blanking end, one makes it fall exactly on it, and the rest make it fall after. For each onset, the bench predicts the cycle where `sw_on` falls as onset plus the regulation length. It predicts the cycle where `fault_n` falls as the later of that cycle and the blanking length, and compares both against the measured cycles.

// File: rtl/ocp_pkg.sv
`timescale 1ns/1ps
package ocp_pkg;
   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_ON    = 3'd1,
      ST_REG   = 3'd2,
      ST_LATCH = 3'd3,
      ST_HOT   = 3'd4
   } ocp_state_e;

   function automatic logic state_conducts(input ocp_state_e s);
      return (s == ST_ON) || (s == ST_REG);
   endfunction
endpackage

// File: rtl/ocp_en_qual.sv
`timescale 1ns/1ps
module ocp_en_qual #(
   parameter bit EN_ACTIVE_HIGH = 1'b1
) (
   input  logic supply_ok,
   input  logic en_pin,
   output logic go
);
   logic en_act;

   generate
      if (EN_ACTIVE_HIGH) begin : g_hi
         assign en_act = en_pin;
      end else begin : g_lo
         assign en_act = ~en_pin;
      end
   endgenerate

   assign go = supply_ok & en_act;
endmodule

// File: rtl/ocp_interval_timer.sv
`timescale 1ns/1ps
module ocp_interval_timer #(
   parameter int TICK_DIV = 50000,
   parameter int TICKS    = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam int CW = $clog2(TICKS + 1);
   localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
   localparam logic [CW-1:0] CNT_END  = CW'(TICKS);

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("ocp_interval_timer: TICK_DIV must be at least 2");
      end
      if (TICKS < 1) begin : g_bad_ticks
         $error("ocp_interval_timer: TICKS must be at least 1");
      end
   endgenerate

   logic [PW-1:0] pre_q;
   logic [CW-1:0] cnt_q;

   assign done = (cnt_q == CNT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (!run) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (!done) begin
         if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   // R5: a stopped timer restarts from zero
   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !done);
   // R4: expiry is sticky while the period runs
   p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && done) |=> (done || !run));
   // R6: count never passes its end value
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_END);
endmodule

// File: rtl/ocp_seq_fsm.sv
`timescale 1ns/1ps
module ocp_seq_fsm
   import ocp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       go,
   input  logic       oc,
   input  logic       ot,
   input  logic       reg_done,
   output ocp_state_e st,
   output logic       fast_q
);
   ocp_state_e nxt;
   logic       fast_nxt;

   always_comb begin
      nxt = st;
      if (!supply_ok) begin
         nxt = ST_OFF;
      end else begin
         case (st)
            ST_OFF:   if (go && !ot) nxt = ST_ON;
            ST_ON: begin
               if (!go)     nxt = ST_OFF;
               else if (ot) nxt = ST_HOT;
               else if (oc) nxt = ST_REG;
            end
            ST_REG: begin
               if (!go)           nxt = ST_OFF;
               else if (ot)       nxt = ST_HOT;
               else if (!oc)      nxt = ST_ON;
               else if (reg_done) nxt = ST_LATCH;
            end
            ST_LATCH: if (!go) nxt = ST_OFF;
            ST_HOT:   if (!go || !ot) nxt = ST_OFF;
            default:  nxt = ST_OFF;
         endcase
      end
   end

   always_comb begin
      fast_nxt = fast_q;
      if (state_conducts(nxt))               fast_nxt = 1'b0;
      else if (!supply_ok)                   fast_nxt = 1'b1;
      else if (st == ST_ON && nxt == ST_OFF) fast_nxt = 1'b0;
      else if (nxt != st)                    fast_nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_OFF;
         fast_q <= 1'b1;
      end else begin
         st     <= nxt;
         fast_q <= fast_nxt;
      end
   end

   // R7: the latched state is left only through enable or supply
   p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LATCH && go) |=> st == ST_LATCH);
endmodule

// File: rtl/ocp_latch_ctrl.sv
`timescale 1ns/1ps
module ocp_latch_ctrl
   import ocp_pkg::*;
#(
   parameter int TICK_DIV       = 50000,
   parameter int REG_TICKS      = 12,
   parameter int BLANK_TICKS    = 12,
   parameter bit EN_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic en_pin,
   input  logic oc_flag,
   input  logic ot_flag,
   output logic sw_on,
   output logic fast_off,
   output logic reg_active,
   output logic fault_n
);
   ocp_state_e st;
   logic go, reg_done, blank_done, fast_q;
   logic reg_run, blank_run;

   ocp_en_qual #(.EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)) u_en (
      .supply_ok (supply_ok),
      .en_pin    (en_pin),
      .go        (go)
   );

   assign reg_run   = (st == ST_REG);
   assign blank_run = (st == ST_ON) || (st == ST_REG) || (st == ST_LATCH);

   ocp_interval_timer #(.TICK_DIV(TICK_DIV), .TICKS(REG_TICKS)) u_reg_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (reg_run),
      .done  (reg_done)
   );

   ocp_interval_timer #(.TICK_DIV(TICK_DIV), .TICKS(BLANK_TICKS)) u_blank_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (blank_run),
      .done  (blank_done)
   );

   ocp_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .go        (go),
      .oc        (oc_flag),
      .ot        (ot_flag),
      .reg_done  (reg_done),
      .st        (st),
      .fast_q    (fast_q)
   );

   assign sw_on      = state_conducts(st);
   assign reg_active = reg_run;
   assign fast_off   = fast_q;
   assign fault_n    = ~((st == ST_LATCH) && blank_done);

   // R2: no conduction without supply and active enable
   p_needs_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> !sw_on);
   // R9: supply loss clears everything and pulls down hard
   p_supply_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (fault_n && fast_off && !sw_on && !reg_active));
   // R7: a reported fault persists while supply and enable persist
   p_single_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_n && go) |=> (!fault_n && !sw_on));
   // R11: over-temperature forces the switch off
   p_hot_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ot_flag |=> !sw_on);
   // R10: turn-off from regulation always uses the fast pulldown
   p_reg_exit_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_active && !sw_on) == 1'b0 && ($fell(sw_on) && $past(reg_active)) |-> fast_off);
endmodule

// File: tb/sim_ocp_latch_ctrl.sv
`timescale 1ns/1ps
module sim_ocp_latch_ctrl;
   localparam int DIV   = 4;
   localparam int RT    = 3;
   localparam int BT    = 5;
   localparam int REG_LEN   = DIV * RT + 1;
   localparam int BLANK_LEN = DIV * BT;

   logic clk = 1'b0, rst_n = 1'b0;
   logic supply_ok = 1'b0, en_pin = 1'b0, en_n = 1'b1, oc_flag = 1'b0, ot_flag = 1'b0;
   logic sw_on, fast_off, reg_active, fault_n;
   logic sw_on1, fast_off1, reg_active1, fault_n1;
   int checks = 0, failures = 0;

   always #10 clk = ~clk;

   ocp_latch_ctrl #(.TICK_DIV(DIV), .REG_TICKS(RT), .BLANK_TICKS(BT), .EN_ACTIVE_HIGH(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en_pin),
      .oc_flag(oc_flag), .ot_flag(ot_flag), .sw_on(sw_on), .fast_off(fast_off),
      .reg_active(reg_active), .fault_n(fault_n));

   ocp_latch_ctrl #(.TICK_DIV(DIV), .REG_TICKS(RT), .BLANK_TICKS(BT), .EN_ACTIVE_HIGH(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en_n),
      .oc_flag(oc_flag), .ot_flag(ot_flag), .sw_on(sw_on1), .fast_off(fast_off1),
      .reg_active(reg_active1), .fault_n(fault_n1));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle();
      en_pin = 1'b0; oc_flag = 1'b0; ot_flag = 1'b0; supply_ok = 1'b1;
      step(); step();
   endtask

   initial begin
      #4000000;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      step(); step();
      chk(sw_on == 0 && fast_off == 1 && reg_active == 0 && fault_n == 1,
          "R1 reset outputs", {sw_on, fast_off, reg_active, fault_n}, 4'b0101);
      rst_n = 1'b1;
      step();

      // R2: enable without supply, then normal turn-on
      en_pin = 1'b1; step();
      chk(sw_on == 0, "R2 no supply", sw_on, 0);
      supply_ok = 1'b1; step();
      chk(sw_on == 1, "R2 turn-on", sw_on, 1);
      idle();

      // R2: active-low variant
      en_n = 1'b0; step();
      chk(sw_on1 == 1 && sw_on == 0, "R2 low-active on", {sw_on1, sw_on}, 2'b10);
      en_n = 1'b1; step();
      chk(sw_on1 == 0 && fast_off1 == 0, "R2 low-active off", {sw_on1, fast_off1}, 2'b00);

      // R4 R6: sweep overcurrent onset across the blanking boundary
      for (int d = 1; d <= 10; d++) begin
         int fall_sw, fall_f, exp_f;
         idle();
         en_pin = 1'b1; step();
         fall_sw = -1; fall_f = -1;
         for (int n = 1; n <= 40; n++) begin
            if (n == d) oc_flag = 1'b1;
            step();
            if (fall_sw < 0 && !sw_on) fall_sw = n;
            if (fall_f < 0 && !fault_n) fall_f = n;
         end
         exp_f = (d + REG_LEN > BLANK_LEN) ? d + REG_LEN : BLANK_LEN;
         chk(fall_sw == d + REG_LEN, "R4 latch cycle", fall_sw, d + REG_LEN);
         chk(fall_f == exp_f, "R6 fault cycle", fall_f, exp_f);
         chk(fast_off == 1, "R4 fast pulldown", fast_off, 1);
         chk(fault_n == 0 && sw_on == 0, "R7 single fault held", {fault_n, sw_on}, 0);
         en_pin = 1'b0; step();
         chk(fault_n == 1, "R8 enable release clears", fault_n, 1);
      end

      // R8: re-enable after a fault gives a new turn-on
      oc_flag = 1'b0; en_pin = 1'b1; step();
      chk(sw_on == 1 && fault_n == 1, "R8 re-enable", {sw_on, fault_n}, 2'b11);

      // R3 R5: overcurrent pulses of growing width
      for (int w = 1; w <= REG_LEN + 1; w++) begin
         int fall;
         idle();
         en_pin = 1'b1; step();
         oc_flag = 1'b1; step();
         chk(reg_active == 1 && sw_on == 1, "R3 regulation", {reg_active, sw_on}, 2'b11);
         for (int k = 2; k <= w; k++) step();
         oc_flag = 1'b0;
         step(); step(); step();
         chk(sw_on == (w <= REG_LEN), "R5 pulse survives", sw_on, (w <= REG_LEN));
         if (w <= REG_LEN) begin
            chk(reg_active == 0, "R5 regulation ends", reg_active, 0);
            oc_flag = 1'b1; fall = -1;
            for (int n = 1; n <= 30; n++) begin
               step();
               if (fall < 0 && !sw_on) fall = n;
            end
            chk(fall == REG_LEN + 1, "R5 fresh period", fall, REG_LEN + 1);
         end
      end

      // R10: slow versus fast turn-off
      idle(); en_pin = 1'b1; step(); step();
      en_pin = 1'b0; step();
      chk(sw_on == 0 && fast_off == 0, "R10 slow disable", {sw_on, fast_off}, 2'b00);
      idle(); en_pin = 1'b1; step();
      oc_flag = 1'b1; step();
      en_pin = 1'b0; step();
      chk(sw_on == 0 && fast_off == 1 && fault_n == 1, "R10 fast disable",
          {sw_on, fast_off, fault_n}, 3'b011);

      // R11: over-temperature
      idle(); en_pin = 1'b1; step();
      ot_flag = 1'b1; step();
      chk(sw_on == 0 && fast_off == 1 && fault_n == 1, "R11 hot off",
          {sw_on, fast_off, fault_n}, 3'b011);
      for (int k = 0; k < 30; k++) step();
      chk(sw_on == 0 && fault_n == 1, "R11 hot held, no fault", {sw_on, fault_n}, 2'b01);
      ot_flag = 1'b0; step();
      chk(sw_on == 0, "R11 restart delay", sw_on, 0);
      step();
      chk(sw_on == 1, "R11 restart", sw_on, 1);

      // R9: supply loss while on and while latched
      supply_ok = 1'b0; step();
      chk(sw_on == 0 && fast_off == 1, "R9 loss while on", {sw_on, fast_off}, 2'b01);
      idle(); en_pin = 1'b1; step(); oc_flag = 1'b1;
      for (int k = 0; k < 30; k++) step();
      chk(fault_n == 0, "R9 latched before loss", fault_n, 0);
      supply_ok = 1'b0; step();
      chk(fault_n == 1 && fast_off == 1 && sw_on == 0 && reg_active == 0,
          "R9 loss clears fault", {fault_n, fast_off, sw_on, reg_active}, 4'b1100);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule